// File: doc/BRIEF.md
# I2C Serial Clock Rate Divider

This block derives the serial clock timing of an I2C master from the system clock. Division happens in two stages. A power-of-two predivider, selected by a 2-bit field, produces a base tick of 1/32, 1/16, 1/8 or 1/4 of the clock rate. A second stage counts those base ticks and flips a phase output every half period. The half-period count is the 8-bit rate value plus a fixed offset of three plus an extra two when the glitch filter is on. The full serial clock period is therefore `P * 2 * (R + 3 + 2*F)` system clocks, where `P` is the predivision, `R` is the rate value and `F` is the filter bit.

A bit engine downstream uses `scl_phase` as the level it should drive on SCL. It can use `half_tick` as a one-cycle warning that the level is about to flip. `pre_tick` is the raw base-rate strobe, available for sampling SDA. Software chooses the divider values. The block only applies them.

The configuration is copied into a shadow set in two cases: when the enable is first seen high, and at the end of every complete period. A register write made during a period therefore never shortens or stretches the half already in progress. Clearing the enable stops everything at the next clock edge.

There is no streaming data path. All pins are plain control and status levels or strobes, and none of them carries a handshake.

Top module: `i2c_sclk_divider`

## Requirements
- R1: The mode input is decoded as follows. Bit 0 is the enable, bits 2:1 are the predivider select `m`, and bit 3 is the filter bit `F`. With bit 0 low, no setting of the other bits produces any activity.
- R2: While the block runs, `pre_tick` is a one-cycle pulse repeating every `2^(5-m)` clocks: 32, 16, 8 or 4 for `m` = 0, 1, 2, 3.
- R3: `scl_phase` stays low for `P*(R+3+2*F)` clocks, then high for the same count. This gives a 50% duty cycle and a full period of `2*P*(R+3+2*F)` clocks.
- R4: Only bits 7:0 of the rate input form `R`. The upper bits have no effect on any output.
- R5: When the enable is sampled low, `scl_phase`, `pre_tick` and `half_tick` are all 0 from the next cycle on, and they stay 0 while the enable stays low.
- R6: A period starts cleanly when the enable rises. The enable is sampled at clock edge e0.
  - The first `pre_tick` is seen `P` cycles after that edge.
  - `scl_phase` first goes high at edge e0 + `P*(R+3+2*F)`.
  - `scl_phase` is low from e0 until then.
- R7: A change to the mode fields or the rate made while running takes effect only after the high half in progress ends. Both halves of each period use one set of values.
- R8: `half_tick` is a one-cycle pulse that only occurs together with `pre_tick`. `scl_phase` flips on the clock edge right after it, and at no other time while the enable is high. There are two `half_tick` pulses per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| mode_reg | input | 4 | Mode: [0] enable, [2:1] predivider select, [3] filter |
| rate_reg | input | REG_W | Rate register; only bits 7:0 are used |
| pre_tick | output | 1 | One-cycle strobe at the predivided base rate |
| half_tick | output | 1 | One-cycle strobe in the cycle before `scl_phase` flips |
| scl_phase | output | 1 | Serial clock level: low half then high half |

## Verification
A predivider counter with the wrong limit shows up at once in the `pre_tick` spacing. A half counter with the wrong limit stretches or shortens the very next half of `scl_phase`. Shadow registers that update at the wrong time show up within one period, as an unequal low/high pair after a mid-period write. A phase or counter that fails to clear on disable becomes visible one cycle after the enable drops, or as a shifted first edge after the next enable.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;
  // Mode field positions: the software side encodes them this way.
  localparam int MODE_W       = 4;
  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_SEL_LSB = 1;
  localparam int MODE_FILT_BIT = 3;

  localparam int SEL_BITS  = 2;
  localparam int RATE_BITS = 8;

  // Configuration set that is held constant for one full serial period.
  typedef struct packed {
    logic [SEL_BITS-1:0]  sel;
    logic                 filt;
    logic [RATE_BITS-1:0] rate;
  } sclk_cfg_t;
endpackage

// File: rtl/i2c_sclk_cfg.sv
module i2c_sclk_cfg
  import i2c_sclk_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MODE_W-1:0]     mode_reg,
  input  logic [REG_W-1:0]      rate_reg,
  input  logic                  period_end,
  output logic                  run,
  output sclk_cfg_t             act
);
  sclk_cfg_t nxt;

  always_comb begin
    nxt.sel  = mode_reg[MODE_SEL_LSB +: SEL_BITS];
    nxt.filt = mode_reg[MODE_FILT_BIT];
    nxt.rate = rate_reg[RATE_BITS-1:0];
  end

  generate
    if (REG_W > RATE_BITS) begin : g_hi
      logic unused_rate_hi;
      assign unused_rate_hi = ^rate_reg[REG_W-1:RATE_BITS];
    end
  endgenerate

  // Shadow copy taken on start and at every full-period boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      act <= '0;
    end else if (!mode_reg[MODE_EN_BIT]) begin
      run <= 1'b0;
    end else if (!run || period_end) begin
      run <= 1'b1;
      act <= nxt;
    end
  end
endmodule

// File: rtl/i2c_sclk_prediv.sv
module i2c_sclk_prediv
  import i2c_sclk_pkg::*;
#(
  parameter int PRE_LOG_MAX = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                run,
  input  logic [SEL_BITS-1:0] sel,
  output logic                tick
);
  localparam int PRE_W   = PRE_LOG_MAX;
  localparam int N_SEL   = 1 << SEL_BITS;

  logic [PRE_W-1:0] lim_tab [N_SEL];
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] lim;

  // One terminal count per select value: 2^(PRE_LOG_MAX - s) - 1.
  generate
    for (genvar s = 0; s < N_SEL; s++) begin : g_lim
      assign lim_tab[s] = PRE_W'((1 << (PRE_LOG_MAX - s)) - 1);
    end
  endgenerate

  assign lim  = lim_tab[sel];
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || !run || (cnt == lim)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/i2c_sclk_halfdiv.sv
module i2c_sclk_halfdiv
  import i2c_sclk_pkg::*;
#(
  parameter int BASE_OFF = 3,
  parameter int FILT_OFF = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 run,
  input  logic                 tick,
  input  logic                 filt,
  input  logic [RATE_BITS-1:0] rate,
  output logic                 phase,
  output logic                 half_tick,
  output logic                 period_end
);
  localparam int MAX_HALF = (1 << RATE_BITS) - 1 + BASE_OFF + FILT_OFF;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;

  assign lim = HALF_W'(rate) + HALF_W'(BASE_OFF - 1)
             + (filt ? HALF_W'(FILT_OFF) : HALF_W'(0));

  assign half_tick  = tick && (cnt == lim);
  assign period_end = half_tick && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!en || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      if (cnt == lim) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_sclk_divider.sv
module i2c_sclk_divider
  import i2c_sclk_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int PRE_LOG_MAX = 5,
  parameter int BASE_OFF    = 3,
  parameter int FILT_OFF    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_reg,
  input  logic [REG_W-1:0]  rate_reg,
  output logic              pre_tick,
  output logic              half_tick,
  output logic              scl_phase
);
  logic      run;
  logic      period_end;
  logic      en;
  sclk_cfg_t act;

  assign en = mode_reg[MODE_EN_BIT];

  i2c_sclk_cfg #(.REG_W(REG_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_reg   (mode_reg),
    .rate_reg   (rate_reg),
    .period_end (period_end),
    .run        (run),
    .act        (act)
  );

  i2c_sclk_prediv #(.PRE_LOG_MAX(PRE_LOG_MAX)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .run   (run),
    .sel   (act.sel),
    .tick  (pre_tick)
  );

  i2c_sclk_halfdiv #(.BASE_OFF(BASE_OFF), .FILT_OFF(FILT_OFF)) u_half (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .run        (run),
    .tick       (pre_tick),
    .filt       (act.filt),
    .rate       (act.rate),
    .phase      (scl_phase),
    .half_tick  (half_tick),
    .period_end (period_end)
  );
endmodule

// File: rtl/i2c_sclk_divider_chk.sv
module i2c_sclk_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pre_tick,
  input logic half_tick,
  input logic scl_phase
);
  // Minimum predivision is 4, so ticks are at least 3 idle cycles apart.
  logic [2:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (pre_tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 3'd7) begin
      gap <= gap + 3'd1;
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_phase && !pre_tick && !half_tick)); // R5

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !half_tick) |=> $stable(scl_phase)); // R8

  AST_HALF_WITH_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> pre_tick); // R8

  AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick); // R2

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && seen) |-> (gap >= 3'd3)); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> !scl_phase); // R6
endmodule

bind i2c_sclk_divider i2c_sclk_divider_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (mode_reg[0]),
  .pre_tick  (pre_tick),
  .half_tick (half_tick),
  .scl_phase (scl_phase)
);

// File: tb/i2c_sclk_divider_test.sv
`timescale 1ns/1ps
module i2c_sclk_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_reg = 4'h0;
  logic [15:0] rate_reg = 16'h0;
  logic        pre_tick, half_tick, scl_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_sclk_divider uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_reg  (mode_reg),
    .rate_reg  (rate_reg),
    .pre_tick  (pre_tick),
    .half_tick (half_tick),
    .scl_phase (scl_phase)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int prediv(input int m);
    return 1 << (5 - m);
  endfunction

  function automatic int halflen(input int m, input int r, input int f);
    return prediv(m) * (r + 3 + 2 * f);
  endfunction

  // Mode encoding: [0] enable, [2:1] select, [3] filter.
  function automatic logic [3:0] mk_mode(input bit en, input int m, input bit f);
    return {f, 2'(m), en};
  endfunction

  // Disable for a few cycles, then enable at a negedge.
  task automatic restart(input int m, input bit f, input logic [15:0] rate);
    @(negedge clk);
    mode_reg = mk_mode(1'b0, m, f);
    rate_reg = rate;
    repeat (3) @(negedge clk);
    mode_reg = mk_mode(1'b1, m, f);
  endtask

  // Count negedges until scl_phase differs from its value at call time.
  task automatic measure_half(output int n);
    logic start;
    start = scl_phase;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (scl_phase == start && n < 5000);
  endtask

  task automatic t_reset;
    check("R5 reset pre_tick", pre_tick, 0);
    check("R5 reset half_tick", half_tick, 0);
    check("R5 reset scl_phase", scl_phase, 0);
  endtask

  task automatic t_prediv(input int m);
    int n;
    restart(m, 1'b0, 16'h0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pre_tick && n < 100);
    check($sformatf("R6 first pre_tick m=%0d", m), n, prediv(m));
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pre_tick && n < 100);
    check($sformatf("R2 pre_tick spacing m=%0d", m), n, prediv(m));
  endtask

  task automatic t_half(input int m, input int r, input bit f, input logic [15:0] rate);
    int n;
    restart(m, f, rate);
    measure_half(n);
    check($sformatf("R6 first rise m=%0d r=%0d f=%0d", m, r, f), n, halflen(m, r, f) + 1);
    measure_half(n);
    check($sformatf("R3 high half m=%0d r=%0d f=%0d", m, r, f), n, halflen(m, r, f));
    measure_half(n);
    check($sformatf("R3 low half m=%0d r=%0d f=%0d", m, r, f), n, halflen(m, r, f));
  endtask

  task automatic t_change;
    int n;
    restart(3, 1'b0, 16'd0);
    measure_half(n);
    // Now in the high half; write new values mid-period.
    mode_reg = mk_mode(1'b1, 2, 1'b1);
    rate_reg = 16'd2;
    measure_half(n);
    check("R7 high half keeps old values", n, halflen(3, 0, 0));
    measure_half(n);
    check("R7 next low half uses new values", n, halflen(2, 2, 1));
    measure_half(n);
    check("R7 next high half uses new values", n, halflen(2, 2, 1));
  endtask

  task automatic t_disable;
    int n;
    int act_cnt;
    restart(3, 1'b0, 16'd1);
    measure_half(n);
    mode_reg = mk_mode(1'b0, 3, 1'b0);
    @(negedge clk);
    check("R5 phase low after disable", scl_phase, 0);
    check("R5 pre_tick low after disable", pre_tick, 0);
    act_cnt = 0;
    mode_reg = 4'b1110;   // all fields set except enable
    repeat (100) begin
      @(negedge clk);
      act_cnt += int'(pre_tick) + int'(half_tick) + int'(scl_phase);
    end
    check("R1 R5 no activity with enable bit clear", act_cnt, 0);
  endtask

  task automatic t_halftick;
    int n;
    int cnt;
    logic ph;
    restart(3, 1'b0, 16'd1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!half_tick && n < 200);
    check("R8 half_tick with pre_tick", pre_tick, 1);
    ph = scl_phase;
    @(negedge clk);
    check("R8 phase flips after half_tick", int'(scl_phase != ph), 1);
    check("R8 half_tick single cycle", half_tick, 0);
    cnt = 0;
    repeat (2 * halflen(3, 1, 0)) begin
      @(negedge clk);
      cnt += int'(half_tick);
    end
    check("R8 two half_ticks per period", cnt, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int m = 0; m < 4; m++) t_prediv(m);
    t_half(3, 0, 1'b0, 16'd0);
    t_half(2, 5, 1'b1, 16'd5);
    t_half(0, 2, 1'b0, 16'd2);
    t_half(3, 255, 1'b1, 16'd255);
    // R4: upper rate bits set, only low byte 0x01 counts.
    t_half(3, 1, 1'b0, 16'hA301);
    t_change();
    t_disable();
    t_halftick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule